// File: doc/BRIEF.md
# Sigma-Delta Ones-Count Decimator

This block turns the one-bit stream of a first-order sigma-delta modulator into multi-bit samples. Each strobed modulator bit is accepted. The ones in a window of 2^n strobes are counted, and the count becomes the sample. The width n is programmable between 1 and 16 and sets both the length of the window and the width of the result. Software can read the decimated word. It can also read the most recent raw modulator bit and run its own filter on the bitstream.

The input stream has only a valid strobe (`mod_stb`). The modulator cannot be stalled, so there is no ready signal on this side, and every strobe is counted. The output is a valid/ready pair. `res_valid` rises when a window completes. The consumer takes the word by holding `res_ready` high in a cycle where `res_valid` is high. Back-pressure never stalls the counting. A word that has not been read when the next window completes is replaced, and `res_valid` stays high. An optional level interrupt follows `res_valid`.

Top module: `sdm_count_decimator`

## Requirements
- R1: After reset, `result` is 0 and `res_valid`, `raw_bit` and `irq` are 0. The active width is DEF_W (12), so the first window is 4096 strobes long whatever `cfg_width` holds.
- R2: `result` equals the number of strobed cycles (`mod_stb`=1) in the window where `mod_bit` was 1. Cycles with `mod_stb`=0 do not count and do not advance the window.
- R3: A window lasts exactly 2^n strobes, where n is the active width. `cfg_width` (unsigned, 5 bits) gives n. A value of 0 is taken as 1, and a value above 16 is taken as 16.
- R4: Every window starts counting from zero, so consecutive results are independent.
- R5: `raw_bit` takes `mod_bit` on every strobed cycle and holds its value on all other cycles.
- R6: A window in which every bit is one gives 2^n-1, the largest n-bit code, and never wraps to 0.
- R7: A new `cfg_width` is sampled only on the last strobe of a window and applies from the next window. The window in progress keeps its length.
- R8: `result` changes only on the clock edge that takes the last strobe of a window. `res_valid` is set on that same edge.
- R9: When `res_valid` and `res_ready` are both 1, `res_valid` clears on the next edge. If a window completes on that same edge, the new word is loaded and `res_valid` stays 1. A word that was never read is overwritten by the next one.
- R10: `irq` is 1 exactly when `res_valid` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_stb | input | 1 | Sample strobe: mod_bit is valid this cycle |
| cfg_width | input | 5 | Requested result width n (clamped to 1..16) |
| irq_en | input | 1 | Interrupt enable |
| res_ready | input | 1 | Consumer takes the held result |
| res_valid | output | 1 | Done flag: unread result is held |
| result | output | 16 | Decimated count, zero-extended to 16 bits |
| raw_bit | output | 1 | Most recent strobed modulator bit |
| irq | output | 1 | Conversion interrupt (level) |

## Verification
A read and the completion of a window can fall in the same cycle. In that cycle one handshake clears the done flag while the other sets it with a fresh word. The bench drives strobes until a held result is pending and exactly one strobe remains in the window. It then raises `res_ready` together with that last strobe. The check passes only if `res_valid` stays 1 and `result` carries the new count, not the old word and not a cleared flag.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  localparam int SDD_MAX_W = 16;
  localparam int SDD_DEF_W = 12;

  // Map a requested width onto the legal range 1..maxw.
  function automatic int clamp_width(int req, int maxw);
    if (req < 1) return 1;
    if (req > maxw) return maxw;
    return req;
  endfunction
endpackage

// File: rtl/sdd_win_ctrl.sv
module sdd_win_ctrl #(
  parameter int MAX_W = 16,
  parameter int DEF_W = 12,
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic [CFG_W-1:0] cfg_w,
  output logic             win_end,
  output logic [MAX_W-1:0] max_code
);
  import sdd_pkg::*;

  logic [CFG_W-1:0] act_w;
  logic [MAX_W-1:0] cnt;

  // Mask of the active width: bit i is set while i < n.
  for (genvar i = 0; i < MAX_W; i++) begin : g_mask
    assign max_code[i] = (32'(act_w) > i);
  end

  assign win_end = stb && (cnt == max_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_w <= CFG_W'(DEF_W);
      cnt   <= '0;
    end else if (win_end) begin
      cnt   <= '0;
      act_w <= CFG_W'(clamp_width(int'(cfg_w), MAX_W));
    end else if (stb) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= max_code);
  assert_width_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(act_w));
endmodule

// File: rtl/sdd_ones_acc.sv
module sdd_ones_acc #(
  parameter int MAX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             sd_bit,
  input  logic             win_end,
  input  logic [MAX_W-1:0] max_code,
  output logic [MAX_W-1:0] sum_sat
);
  logic [MAX_W:0] ones;
  logic [MAX_W:0] nxt;

  assign nxt     = ones + {{MAX_W{1'b0}}, sd_bit};
  assign sum_sat = (nxt > {1'b0, max_code}) ? max_code : nxt[MAX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)       ones <= '0;
    else if (win_end) ones <= '0;
    else if (stb)     ones <= nxt;
  end

  assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> ones == '0);
  assert_ones_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= {1'b0, max_code});
endmodule

// File: rtl/sdd_result_reg.sv
module sdd_result_reg #(
  parameter int MAX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             sd_bit,
  input  logic             win_end,
  input  logic [MAX_W-1:0] sum_sat,
  input  logic             rd,
  input  logic             irq_en,
  output logic [MAX_W-1:0] result,
  output logic             valid,
  output logic             raw,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      valid  <= 1'b0;
      raw    <= 1'b0;
    end else begin
      if (win_end) begin
        result <= sum_sat;
        valid  <= 1'b1;
      end else if (rd) begin
        valid <= 1'b0;
      end
      if (stb) raw <= sd_bit;
    end
  end

  assign irq = valid && irq_en;

  assert_done_on_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> valid);
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(result));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid && rd && !win_end |=> !valid);
  assert_raw_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> $stable(raw));
endmodule

// File: rtl/sdm_count_decimator.sv
module sdm_count_decimator #(
  parameter int MAX_W = sdd_pkg::SDD_MAX_W,
  parameter int DEF_W = sdd_pkg::SDD_DEF_W,
  parameter int CFG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_bit,
  input  logic             mod_stb,
  input  logic [CFG_W-1:0] cfg_width,
  input  logic             irq_en,
  input  logic             res_ready,
  output logic             res_valid,
  output logic [MAX_W-1:0] result,
  output logic             raw_bit,
  output logic             irq
);
  logic             win_end;
  logic [MAX_W-1:0] max_code;
  logic [MAX_W-1:0] sum_sat;

  sdd_win_ctrl #(.MAX_W(MAX_W), .DEF_W(DEF_W), .CFG_W(CFG_W)) u_win (
    .clk(clk), .rst_n(rst_n), .stb(mod_stb), .cfg_w(cfg_width),
    .win_end(win_end), .max_code(max_code)
  );

  sdd_ones_acc #(.MAX_W(MAX_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .stb(mod_stb), .sd_bit(mod_bit),
    .win_end(win_end), .max_code(max_code), .sum_sat(sum_sat)
  );

  sdd_result_reg #(.MAX_W(MAX_W)) u_res (
    .clk(clk), .rst_n(rst_n), .stb(mod_stb), .sd_bit(mod_bit),
    .win_end(win_end), .sum_sat(sum_sat), .rd(res_ready), .irq_en(irq_en),
    .result(result), .valid(res_valid), .raw(raw_bit), .irq(irq)
  );

  assert_result_fits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> result <= $past(max_code));
endmodule

// File: tb/sim_sdm_count_decimator.sv
module sim_sdm_count_decimator;
  localparam int MAX_W = 16;
  localparam int CFG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mod_bit = 1'b0;
  logic             mod_stb = 1'b0;
  logic [CFG_W-1:0] cfg_width = '0;
  logic             irq_en = 1'b0;
  logic             res_ready = 1'b0;
  logic             res_valid;
  logic [MAX_W-1:0] result;
  logic             raw_bit;
  logic             irq;

  sdm_count_decimator u0 (
    .clk(clk), .rst_n(rst_n), .mod_bit(mod_bit), .mod_stb(mod_stb),
    .cfg_width(cfg_width), .irq_en(irq_en), .res_ready(res_ready),
    .res_valid(res_valid), .result(result), .raw_bit(raw_bit), .irq(irq)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Bench model state, built from the requirements.
  int   m_w = 12;
  int   m_cnt = 0;
  int   m_ones = 0;
  int   m_res = 0;
  logic m_valid = 1'b0;
  logic m_raw = 1'b0;

  function automatic int clampw(int c);
    if (c < 1) return 1;
    if (c > 16) return 16;
    return c;
  endfunction

  function automatic int sat_count(int ones, int w);
    int mx = (1 << w) - 1;
    return (ones > mx) ? mx : ones;
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic s, logic b, logic r, string tag);
    @(negedge clk);
    mod_stb = s; mod_bit = b; res_ready = r;
    if (m_valid && r) m_valid = 1'b0;
    if (s && m_cnt == (1 << m_w) - 1) begin
      m_res = sat_count(m_ones + int'(b), m_w);
      m_valid = 1'b1;
      m_w = clampw(int'(cfg_width));
      m_cnt = 0; m_ones = 0;
    end else if (s) begin
      m_cnt++; m_ones += int'(b);
    end
    if (s) m_raw = b;
    @(posedge clk); #1;
    chk({tag, " result"}, int'(result), m_res);
    chk({tag, " valid"}, int'(res_valid), int'(m_valid));
    chk({tag, " raw R5"}, int'(raw_bit), int'(m_raw));
    chk({tag, " irq R10"}, int'(irq), int'(m_valid && irq_en));
  endtask

  initial begin
    #(190000 * 10);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset valid", int'(res_valid), 0);
    chk("R1 reset raw", int'(raw_bit), 0);
    chk("R1 reset irq", int'(irq), 0);

    // First window is the default width even though cfg asks for 3 (R1, R7).
    cfg_width = 5'd3;
    for (int i = 0; i < 4095; i++) step(1'b1, 1'($urandom % 2), 1'b0, "R1 R2");
    chk("R7 no early end", int'(res_valid), 0);
    step(1'b1, 1'($urandom % 2), 1'b0, "R8 default window end");
    chk("R8 done after 4096", int'(res_valid), 1);

    // n=3, all ones with idle gaps carrying ones: saturates to 7 (R6, R2).
    irq_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, 1'b0, "R2 idle ignored");
      step(1'b1, 1'b1, 1'b0, "R6");
    end
    chk("R6 saturate n=3", int'(result), 7);
    chk("R10 irq raised", int'(irq), 1);
    step(1'b0, 1'b0, 1'b1, "R9 read");
    chk("R9 read clears", int'(res_valid), 0);

    // Raw bit holds without a strobe (R5).
    step(1'b1, 1'b1, 1'b0, "R5 strobe");
    step(1'b0, 1'b0, 1'b0, "R5 hold");
    chk("R5 raw held", int'(raw_bit), 1);

    // Constrained random: widths 0..6 (0 clamps to 1), gaps, sparse reads.
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 50 == 0) cfg_width = CFG_W'($urandom % 7);
      if ($urandom % 40 == 0) irq_en = ~irq_en;
      step(1'($urandom % 4 != 0), 1'($urandom % 2), 1'($urandom % 10 == 0),
           "R2 R3 R4 R9");
    end

    // Coincident read and window completion (R9).
    cfg_width = 5'd2;
    irq_en = 1'b1;
    while (!(m_valid && m_cnt == (1 << m_w) - 1))
      step(1'b1, 1'($urandom % 2), 1'b0, "R4 prep");
    step(1'b1, 1'b1, 1'b1, "R9 coincident");
    chk("R9 coincident keeps valid", int'(res_valid), 1);

    // Unread result is overwritten by the next window (R9).
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, "R9 overwrite");
    chk("R9 overwritten by zero count", int'(result), 0);
    irq_en = 1'b0;
    step(1'b0, 1'b0, 1'b0, "R10 disabled");
    chk("R10 irq masked", int'(irq), 0);

    // Over-range request clamps to 16; all ones saturate to 65535 (R3, R6).
    cfg_width = 5'd31;
    while (!(m_w == 16 && m_cnt == 0))
      step(1'b1, 1'b0, 1'b0, "R3 align");
    for (int i = 0; i < 65535; i++) step(1'b1, 1'b1, 1'b1, "R3 long");
    chk("R3 no end before 65536", int'(res_valid), 0);
    step(1'b1, 1'b1, 1'b0, "R6 max");
    chk("R6 saturate n=16", int'(result), 65535);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule